// File: doc/BRIEF.md
# Legacy Processor Presence Map

This block holds a byte-readable map with one flag per possible processor. The flag index is the processor's interrupt-controller ID. Platform logic reports each hot-add through a strobe and an ID. The block sets the matching flag and latches a general-purpose event status (event bit 2). It raises the system interrupt while that status is latched and software has enabled it. Processors are never removed, so a flag once set stays set until reset. Bit 0 stands for the boot processor and always reads as 1.

Software cannot alter the map by writing to it. One write has a side effect: storing the byte 0x00 anywhere in the first 32-bit word moves the platform to the newer hotplug register interface. The block reports this on a sticky mode output. After the switch the map still answers reads, but it no longer takes hot-adds or raises events. Address-window decoding and interrupt routing to software are handled outside the block.

Top module: `cpumap_legacy_port`

## Requirements
- R1: After reset the map holds only bit 0, `modern_mode`, `gpe_sts`, `sci` and `rd_data` are all 0.
- R2: A read of byte address a returns map bits 8a+7 down to 8a on `rd_data` one clock after the read cycle, and `rd_data` holds until the next read.
- R3: Bit 0 (boot processor) always reads as 1.
- R4: A hot-add in legacy mode with ID below `N_CPU` sets map bit ID, and the result is visible to reads from the next cycle. A hot-add with ID at or above `N_CPU` changes nothing.
- R5: An accepted hot-add sets `gpe_sts` on the next clock. `sci` is high exactly while `gpe_sts` and `gpe_en` are both high.
- R6: `gpe_sts` stays set until a cycle with `gpe_clr` high. When a hot-add and a clear arrive together, the status stays set.
- R7: No write ever changes the map contents.
- R8: A write with data 0x00 to byte address 0, 1, 2 or 3 sets `modern_mode` on the next clock. A write with non-zero data, or to address 4 or above, leaves it 0.
- R9: `modern_mode` stays set until reset. While it is set, hot-adds neither change the map nor set `gpe_sts`, and reads still return the map.
- R10: Reads of byte addresses at or above ceil(`N_CPU`/8) return 0x00.
- R11: No event clears a map bit; only reset does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Byte access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Byte offset inside the map window |
| acc_wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data, registered |
| plug_valid | input | 1 | Hot-add strobe |
| plug_id | input | ID_W | Interrupt-controller ID of the added processor |
| gpe_en | input | 1 | Enable for event bit 2 |
| gpe_clr | input | 1 | Write-one-to-clear strobe for the event status |
| gpe_sts | output | 1 | Latched event status (event bit 2) |
| sci | output | 1 | System interrupt request |
| modern_mode | output | 1 | Sticky flag: newer hotplug interface selected |

## Verification
A wrong map bit shows up on `rd_data` one clock after a read of the byte that holds it. The bench therefore reads back the affected byte right after every hot-add and every ignored write. A lost or stuck event status shows on `gpe_sts` and `sci` one clock after the hot-add or clear that should have moved it. A wrongly decoded mode write shows on `modern_mode` in the next cycle. It also shows as a hot-add that still lands, or does not land, in the map afterwards.

// File: rtl/cpumap_pkg.sv
package cpumap_pkg;

    localparam int BYTE_W      = 8;
    localparam int SWITCH_BYTES = 4;   // first 32-bit word of the map

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_e;

    typedef struct packed {
        logic set;   // accepted hot-add this cycle
        logic clr;   // software clear strobe
        logic en;    // software enable
    } evt_ctl_t;

    function automatic acc_kind_e acc_kind(input logic valid, input logic write);
        if (!valid)      return ACC_IDLE;
        else if (write)  return ACC_WRITE;
        else             return ACC_READ;
    endfunction

    function automatic int bytes_for(input int bits);
        return (bits + BYTE_W - 1) / BYTE_W;
    endfunction

endpackage

// File: rtl/cpumap_store.sv
module cpumap_store #(
    parameter int N_CPU = 64,
    parameter int ID_W  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_en,
    input  logic [ID_W-1:0]  set_id,
    output logic [N_CPU-1:0] map_q
);
    // boot processor flag is fixed
    assign map_q[0] = 1'b1;

    for (genvar g = 1; g < N_CPU; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                map_q[g] <= 1'b0;
            else if (set_en && (set_id == ID_W'(g)))
                map_q[g] <= 1'b1;
        end
    end
endmodule

// File: rtl/cpumap_reader.sv
module cpumap_reader
    import cpumap_pkg::*;
#(
    parameter int N_CPU  = 64,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [N_CPU-1:0]  map,
    output logic [BYTE_W-1:0] rd_data
);
    localparam int NBYTES = bytes_for(N_CPU);
    localparam int PAD_W  = NBYTES * BYTE_W;
    localparam int IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;

    logic [PAD_W-1:0]  padded;
    logic [BYTE_W-1:0] lanes [NBYTES];
    logic [BYTE_W-1:0] sel;
    logic [IDX_W-1:0]  idx;

    assign padded = PAD_W'(map);

    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        assign lanes[g] = padded[g*BYTE_W +: BYTE_W];
    end

    always_comb begin
        idx = IDX_W'(addr);
        sel = '0;
        if (32'(addr) < NBYTES)
            sel = lanes[idx];
    end

    always_ff @(posedge clk) begin
        if (rst)
            rd_data <= '0;
        else if (rd_en)
            rd_data <= sel;
    end
endmodule

// File: rtl/cpumap_mode.sv
module cpumap_mode
    import cpumap_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic              modern_q
);
    logic hit;

    assign hit = wr_en && (32'(addr) < SWITCH_BYTES) && (wdata == '0);

    always_ff @(posedge clk) begin
        if (rst)
            modern_q <= 1'b0;
        else if (hit)
            modern_q <= 1'b1;
    end
endmodule

// File: rtl/cpumap_event.sv
module cpumap_event
    import cpumap_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  evt_ctl_t ctl,
    output logic     sts_q,
    output logic     irq
);
    always_ff @(posedge clk) begin
        if (rst)
            sts_q <= 1'b0;
        else if (ctl.set)
            sts_q <= 1'b1;        // a new event wins over a clear
        else if (ctl.clr)
            sts_q <= 1'b0;
    end

    assign irq = sts_q & ctl.en;
endmodule

// File: rtl/cpumap_legacy_port.sv
module cpumap_legacy_port
    import cpumap_pkg::*;
#(
    parameter int N_CPU  = 64,
    parameter int ID_W   = 8,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [7:0]        acc_wdata,
    output logic [7:0]        rd_data,
    input  logic              plug_valid,
    input  logic [ID_W-1:0]   plug_id,
    input  logic              gpe_en,
    input  logic              gpe_clr,
    output logic              gpe_sts,
    output logic              sci,
    output logic              modern_mode
);
    acc_kind_e        kind;
    logic             accept;
    logic [N_CPU-1:0] map_q;
    evt_ctl_t         ctl;

    assign kind   = acc_kind(acc_valid, acc_write);
    assign accept = plug_valid && !modern_mode && (32'(plug_id) < N_CPU);

    assign ctl.set = accept;
    assign ctl.clr = gpe_clr;
    assign ctl.en  = gpe_en;

    cpumap_store #(.N_CPU(N_CPU), .ID_W(ID_W)) store_i (
        .clk    (clk),
        .rst    (rst),
        .set_en (accept),
        .set_id (plug_id),
        .map_q  (map_q)
    );

    cpumap_reader #(.N_CPU(N_CPU), .ADDR_W(ADDR_W)) reader_i (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (kind == ACC_READ),
        .addr    (acc_addr),
        .map     (map_q),
        .rd_data (rd_data)
    );

    cpumap_mode #(.ADDR_W(ADDR_W)) mode_i (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (kind == ACC_WRITE),
        .addr     (acc_addr),
        .wdata    (acc_wdata),
        .modern_q (modern_mode)
    );

    cpumap_event event_i (
        .clk   (clk),
        .rst   (rst),
        .ctl   (ctl),
        .sts_q (gpe_sts),
        .irq   (sci)
    );
endmodule

// File: rtl/cpumap_legacy_chk.sv
module cpumap_legacy_chk #(
    parameter int N_CPU  = 64,
    parameter int ID_W   = 8,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              plug_valid,
    input logic [ID_W-1:0]   plug_id,
    input logic              gpe_clr,
    input logic              gpe_sts,
    input logic              modern_mode,
    input logic [7:0]        rd_data,
    input logic [N_CPU-1:0]  map_q
);
    // R3
    boot_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_write && acc_addr == '0) |=> rd_data[0]);

    // R5
    event_raise_chk: assert property (@(posedge clk) disable iff (rst)
        (plug_valid && !modern_mode && 32'(plug_id) < N_CPU) |=> gpe_sts);

    // R6
    status_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (gpe_sts && !gpe_clr) |=> gpe_sts);

    // R7
    write_inert_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_write && !plug_valid) |=> $stable(map_q));

    // R9
    mode_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        modern_mode |=> modern_mode);

    // R9
    modern_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        modern_mode |=> $stable(map_q));

    // R11
    no_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !$isunknown($past(map_q)) |-> ((map_q & $past(map_q)) == $past(map_q)));
endmodule

bind cpumap_legacy_port cpumap_legacy_chk #(.N_CPU(N_CPU), .ID_W(ID_W), .ADDR_W(ADDR_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .acc_valid   (acc_valid),
    .acc_write   (acc_write),
    .acc_addr    (acc_addr),
    .plug_valid  (plug_valid),
    .plug_id     (plug_id),
    .gpe_clr     (gpe_clr),
    .gpe_sts     (gpe_sts),
    .modern_mode (modern_mode),
    .rd_data     (rd_data),
    .map_q       (map_q)
);

// File: tb/cpumap_legacy_port_tb_top.sv
module cpumap_legacy_port_tb_top;
    localparam int N_CPU  = 64;
    localparam int ID_W   = 8;
    localparam int ADDR_W = 5;

    // vector: [29:28] op (0 read, 1 hot-add, 2 write), [27:20] addr,
    //         [19:12] data or ID, [11:4] expected read byte, [3:0] requirement number
    localparam int NV = 16;
    localparam logic [29:0] VEC [NV] = '{
        {2'd0, 8'd0,  8'h00, 8'h01, 4'd3 },  // R3 boot bit after reset
        {2'd0, 8'd1,  8'h00, 8'h00, 4'd2 },  // R2 empty byte
        {2'd1, 8'd0,  8'd5,  8'h00, 4'd4 },  // R4 add ID 5
        {2'd0, 8'd0,  8'h00, 8'h21, 4'd4 },
        {2'd1, 8'd0,  8'd13, 8'h00, 4'd4 },  // R4 add ID 13
        {2'd0, 8'd1,  8'h00, 8'h20, 4'd2 },
        {2'd1, 8'd0,  8'd63, 8'h00, 4'd4 },  // R4 top ID
        {2'd0, 8'd7,  8'h00, 8'h80, 4'd2 },
        {2'd2, 8'd0,  8'hFF, 8'h00, 4'd7 },  // R7 write ignored
        {2'd0, 8'd0,  8'h00, 8'h21, 4'd7 },
        {2'd2, 8'd1,  8'h5A, 8'h00, 4'd7 },
        {2'd0, 8'd1,  8'h00, 8'h20, 4'd7 },
        {2'd1, 8'd0,  8'd70, 8'h00, 4'd4 },  // R4 out-of-range ID ignored
        {2'd0, 8'd8,  8'h00, 8'h00, 4'd10},  // R10 past the map
        {2'd0, 8'd31, 8'h00, 8'h00, 4'd10},
        {2'd0, 8'd0,  8'h00, 8'h21, 4'd11}   // R11 bits kept
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              acc_valid = 1'b0, acc_write = 1'b0;
    logic [ADDR_W-1:0] acc_addr = '0;
    logic [7:0]        acc_wdata = '0;
    logic [7:0]        rd_data;
    logic              plug_valid = 1'b0;
    logic [ID_W-1:0]   plug_id = '0;
    logic              gpe_en = 1'b0, gpe_clr = 1'b0;
    logic              gpe_sts, sci, modern_mode;

    int applied = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    cpumap_legacy_port #(.N_CPU(N_CPU), .ID_W(ID_W), .ADDR_W(ADDR_W)) dut_i (.*);

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        applied++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%02h, expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = wr; acc_addr = ADDR_W'(a); acc_wdata = d;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    task automatic hotadd(input logic [7:0] id, input logic clr);
        @(negedge clk);
        plug_valid = 1'b1; plug_id = id; gpe_clr = clr;
        @(negedge clk);
        plug_valid = 1'b0; gpe_clr = 1'b0;
    endtask

    task automatic clear_sts();
        @(negedge clk);
        gpe_clr = 1'b1;
        @(negedge clk);
        gpe_clr = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        do_reset();
        check("R1 rd_data", rd_data, 8'h00);
        check("R1 modern_mode", {7'd0, modern_mode}, 8'h00);
        check("R1 gpe_sts", {7'd0, gpe_sts}, 8'h00);
        check("R1 sci", {7'd0, sci}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            case (VEC[i][29:28])
                2'd0: begin
                    access(1'b0, VEC[i][27:20], 8'h00);
                    check($sformatf("R%0d vector %0d", VEC[i][3:0], i), rd_data, VEC[i][11:4]);
                end
                2'd1: hotadd(VEC[i][19:12], 1'b0);
                default: access(1'b1, VEC[i][27:20], VEC[i][19:12]);
            endcase
        end

        // R5 status latched and interrupt gated by enable
        check("R5 gpe_sts after hot-add", {7'd0, gpe_sts}, 8'h01);
        check("R5 sci disabled", {7'd0, sci}, 8'h00);
        gpe_en = 1'b1;
        #1;
        check("R5 sci enabled", {7'd0, sci}, 8'h01);
        // R6 hold then clear
        repeat (3) @(negedge clk);
        check("R6 status held", {7'd0, gpe_sts}, 8'h01);
        clear_sts();
        check("R6 status cleared", {7'd0, gpe_sts}, 8'h00);
        check("R5 sci follows status", {7'd0, sci}, 8'h00);
        hotadd(8'd20, 1'b1);
        check("R6 set beats clear", {7'd0, gpe_sts}, 8'h01);
        clear_sts();
        hotadd(8'd64, 1'b0);
        check("R4 out-of-range raises nothing", {7'd0, gpe_sts}, 8'h00);

        // R8 mode switch decode
        access(1'b1, 8'd0, 8'h01);
        check("R8 non-zero data", {7'd0, modern_mode}, 8'h00);
        access(1'b1, 8'd4, 8'h00);
        check("R8 address 4", {7'd0, modern_mode}, 8'h00);
        access(1'b1, 8'd3, 8'h00);
        check("R8 zero to byte 3", {7'd0, modern_mode}, 8'h01);

        // R9 frozen map and no events in modern mode
        hotadd(8'd7, 1'b0);
        check("R9 no event", {7'd0, gpe_sts}, 8'h00);
        access(1'b0, 8'd0, 8'h00);
        check("R9 map frozen", rd_data, 8'h21);
        access(1'b1, 8'd0, 8'hFF);
        check("R9 sticky", {7'd0, modern_mode}, 8'h01);
        access(1'b0, 8'd2, 8'h00);
        check("R9 reads still served", rd_data, 8'h10);

        // R1 and R11 reset is the only way back
        do_reset();
        check("R1 modern cleared by reset", {7'd0, modern_mode}, 8'h00);
        access(1'b0, 8'd0, 8'h00);
        check("R1 map reset", rd_data, 8'h01);
        access(1'b0, 8'd7, 8'h00);
        check("R11 reset clears top byte", rd_data, 8'h00);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
            $finish;
        end
    end
endmodule